// File: doc/BRIEF.md
# Passive Serial FPGA Configuration Loader

This block loads a configuration image into an SRAM-based FPGA through its passive serial pins. A `start` pulse begins a job. The loader first runs the reset handshake on the target's configuration-request pin. It then takes `byteCount` bytes from a valid/ready byte stream and shifts each byte out, least significant bit first, on a serial data/clock pair. When the image has been sent, it keeps clocking zero data until the target raises its done flag. It then gives a fixed burst of trailing clocks so the target enters user mode.

The PCI reset output is held low for the whole job and is released when the loader returns to idle. Each wait on the target is bounded by the `timeoutLimit` input. A job ends either with `done` high and no error, or with `done` high and a two-bit code that names the wait that expired. The serial clock half-period, the two handshake delays and the trailing clock count are parameters.

Top module: `pser_cfg_loader`

## Requirements
- R1: After reset, the outputs are: `cfgStartN`=1, `cfgClk`=0, `pciRstN`=1, `busy`=0, `done`=0, `err`=0 and `inReady`=0.
- R2: `pciRstN` is low in every cycle in which `busy` is high, and high in every cycle in which the loader is idle.
- R3: After `start`, `cfgStartN` stays high for exactly LONG_DLY cycles. It then goes low and stays low for at least SHORT_DLY cycles, and until `statusN` has been seen low. It returns high only after `statusN` was low in the previous cycle.
- R4: If `statusN` does not fall, `cfgStartN` stays low for SHORT_DLY + timeoutLimit + 1 cycles. The job then ends with `err`=1.
- R5: If `statusN` does not rise again within timeoutLimit + 1 cycles after `cfgStartN` returns high, the job ends with `err`=2 and no byte is requested.
- R6: Each byte is sent least significant bit first, with one `cfgClk` rising edge per bit and eight per byte. `cfgData` changes only while `cfgClk` is low, and does not change in the cycle in which `cfgClk` rises.
- R7: `inReady` is high only while `cfgClk` is low and the previous byte has been fully shifted. Exactly `byteCount` bytes are accepted, each on a cycle with `inValid` and `inReady` both high.
- R8: After the last byte, the loader issues clocks with `cfgData`=0 until `confDone` is high. If timeoutLimit such clocks pass without `confDone`, the job ends with `err`=3.
- R9: Once `confDone` is seen, exactly TRAIL_CLKS (default 10) further rising edges of `cfgClk` occur. The job then ends with `done`=1 and `err`=0.
- R10: A `start` pulse while `busy` is high has no effect. A new `start` clears `done` and `err` in the cycle after it is taken.
- R11: A job with `byteCount`=0 requests no byte and goes straight to the zero-data clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job; taken only when idle |
| byteCount | input | CNT_W | Number of image bytes for the job |
| timeoutLimit | input | TO_W | Bound on each wait (cycles for status waits, clocks for the done wait) |
| inData | input | 8 | Image byte |
| inValid | input | 1 | Image byte is valid |
| inReady | output | 1 | Loader can take a byte |
| statusN | input | 1 | Target status pin, active low |
| confDone | input | 1 | Target configuration done flag |
| cfgStartN | output | 1 | Configuration request to target, active low |
| cfgData | output | 1 | Serial configuration data |
| cfgClk | output | 1 | Serial configuration clock |
| pciRstN | output | 1 | PCI reset, held low during a job |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job finished (check `err`) |
| err | output | 2 | 0 none, 1 status never fell, 2 status never rose, 3 done never rose |

## Verification
The bound checker checks, on every cycle, the relations between pins. PCI reset follows the busy state. Serial data is stable across each clock rise and through the high phase. The request pin is released only after status was low. Ready is asserted only while the clock is low. Done never coexists with busy. The counted quantities can only be shown by the bench's scenarios, since each needs a whole job in view: the exact length of the high and low request phases, the order of the bits received per byte, the number of accepted bytes, the number of zero-data clocks before a done timeout, the trailing clock count, and each of the three error codes.

// File: rtl/pser_cfg_pkg.sv
package pser_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LONG, ST_SHORT, ST_WAITLO,
    ST_RISE, ST_SHIFT, ST_DONEWAIT, ST_TRAIL
  } cfgState_t;

  localparam logic [1:0] ERR_NONE   = 2'd0;
  localparam logic [1:0] ERR_NOLOW  = 2'd1;
  localparam logic [1:0] ERR_NOHIGH = 2'd2;
  localparam logic [1:0] ERR_NODONE = 2'd3;

  // strobes from control to the bit engine
  typedef struct packed {
    logic loadByte;  // capture inData into the shifter
    logic loadZero;  // clear the shifter
    logic go;        // run one serial clock period
  } bitCmd_t;

endpackage

// File: rtl/pser_cfg_dp.sv
module pser_cfg_dp
  import pser_cfg_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  bitCmd_t    cmd,
  input  logic [7:0] inData,
  output logic       cfgData,
  output logic       cfgClk,
  output logic       bitActive
);
  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [7:0]       shiftReg;
  logic [DIV_W-1:0] divCnt;
  logic             clkHi;
  logic             phaseEnd;
  logic             bitEnd;

  assign phaseEnd  = bitActive && (divCnt == DIV_W'(DIV_HALF - 1));
  assign bitEnd    = phaseEnd && clkHi;
  assign cfgData   = shiftReg[0];
  assign cfgClk    = clkHi;

  // serial clock: low phase then high phase, DIV_HALF cycles each
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitActive <= 1'b0;
      clkHi     <= 1'b0;
      divCnt    <= '0;
    end else if (!bitActive) begin
      if (cmd.go) begin
        bitActive <= 1'b1;
        clkHi     <= 1'b0;
        divCnt    <= '0;
      end
    end else if (phaseEnd) begin
      divCnt <= '0;
      if (clkHi) begin
        clkHi     <= 1'b0;
        bitActive <= 1'b0;
      end else begin
        clkHi <= 1'b1;
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // shifter advances on the falling edge of the serial clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (cmd.loadByte) shiftReg <= inData;
    else if (cmd.loadZero) shiftReg <= '0;
    else if (bitEnd)       shiftReg <= {1'b0, shiftReg[7:1]};
  end

endmodule

// File: rtl/pser_cfg_ctrl.sv
module pser_cfg_ctrl
  import pser_cfg_pkg::*;
#(
  parameter int LONG_DLY   = 400,
  parameter int SHORT_DLY  = 4,
  parameter int CNT_W      = 16,
  parameter int TO_W       = 16,
  parameter int TRAIL_CLKS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] byteCount,
  input  logic [TO_W-1:0]  timeoutLimit,
  input  logic             inValid,
  output logic             inReady,
  input  logic             statusN,
  input  logic             confDone,
  input  logic             bitActive,
  output bitCmd_t          cmd,
  output logic             cfgStartN,
  output logic             pciRstN,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err
);
  localparam int DLY_W   = $clog2(LONG_DLY + 1);
  localparam int TMR_W   = (DLY_W > TO_W) ? DLY_W : TO_W;
  localparam int TRAIL_W = $clog2(TRAIL_CLKS + 1);

  cfgState_t          state;
  logic [TMR_W-1:0]   tmr;
  logic [CNT_W-1:0]   bytesLeft;
  logic [2:0]         bitsLeft;
  logic [TRAIL_W-1:0] trailLeft;
  logic               tmrAtLimit;

  assign tmrAtLimit = (tmr == TMR_W'(timeoutLimit));
  assign cfgStartN  = !(state == ST_SHORT || state == ST_WAITLO);
  assign pciRstN    = (state == ST_IDLE);
  assign busy       = (state != ST_IDLE);

  always_comb begin
    cmd     = '0;
    inReady = 1'b0;
    unique case (state)
      ST_SHIFT: if (!bitActive) begin
        if (bitsLeft != 3'd0) cmd.go = 1'b1;
        else if (bytesLeft != '0) begin
          inReady = 1'b1;
          if (inValid) begin
            cmd.loadByte = 1'b1;
            cmd.go       = 1'b1;
          end
        end
      end
      ST_DONEWAIT: if (!bitActive && !confDone && !tmrAtLimit) begin
        cmd.loadZero = 1'b1;
        cmd.go       = 1'b1;
      end
      ST_TRAIL: if (!bitActive && trailLeft != '0) cmd.go = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tmr       <= '0;
      bytesLeft <= '0;
      bitsLeft  <= '0;
      trailLeft <= '0;
      done      <= 1'b0;
      err       <= ERR_NONE;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state     <= ST_LONG;
          tmr       <= '0;
          bytesLeft <= byteCount;
          bitsLeft  <= '0;
          done      <= 1'b0;
          err       <= ERR_NONE;
        end
        ST_LONG: if (tmr == TMR_W'(LONG_DLY - 1)) begin
          state <= ST_SHORT;
          tmr   <= '0;
        end else tmr <= tmr + 1'b1;
        ST_SHORT: if (tmr == TMR_W'(SHORT_DLY - 1)) begin
          state <= ST_WAITLO;
          tmr   <= '0;
        end else tmr <= tmr + 1'b1;
        ST_WAITLO: if (!statusN) begin
          state <= ST_RISE;
          tmr   <= '0;
        end else if (tmrAtLimit) begin
          state <= ST_IDLE;
          done  <= 1'b1;
          err   <= ERR_NOLOW;
        end else tmr <= tmr + 1'b1;
        ST_RISE: if (statusN) begin
          state <= ST_SHIFT;
        end else if (tmrAtLimit) begin
          state <= ST_IDLE;
          done  <= 1'b1;
          err   <= ERR_NOHIGH;
        end else tmr <= tmr + 1'b1;
        ST_SHIFT: if (!bitActive) begin
          if (bitsLeft != 3'd0) bitsLeft <= bitsLeft - 1'b1;
          else if (bytesLeft != '0) begin
            if (inValid) begin
              bytesLeft <= bytesLeft - 1'b1;
              bitsLeft  <= 3'd7;
            end
          end else begin
            state <= ST_DONEWAIT;
            tmr   <= '0;
          end
        end
        ST_DONEWAIT: if (!bitActive) begin
          if (confDone) begin
            state     <= ST_TRAIL;
            trailLeft <= TRAIL_W'(TRAIL_CLKS);
          end else if (tmrAtLimit) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            err   <= ERR_NODONE;
          end else tmr <= tmr + 1'b1;
        end
        ST_TRAIL: if (!bitActive) begin
          if (trailLeft != '0) trailLeft <= trailLeft - 1'b1;
          else begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pser_cfg_loader.sv
module pser_cfg_loader
  import pser_cfg_pkg::*;
#(
  parameter int DIV_HALF   = 2,
  parameter int LONG_DLY   = 400,
  parameter int SHORT_DLY  = 4,
  parameter int CNT_W      = 16,
  parameter int TO_W       = 16,
  parameter int TRAIL_CLKS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] byteCount,
  input  logic [TO_W-1:0]  timeoutLimit,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  input  logic             statusN,
  input  logic             confDone,
  output logic             cfgStartN,
  output logic             cfgData,
  output logic             cfgClk,
  output logic             pciRstN,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err
);
  bitCmd_t bitCmd;
  logic    bitActive;

  pser_cfg_ctrl #(
    .LONG_DLY(LONG_DLY), .SHORT_DLY(SHORT_DLY), .CNT_W(CNT_W),
    .TO_W(TO_W), .TRAIL_CLKS(TRAIL_CLKS)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount),
    .timeoutLimit(timeoutLimit), .inValid(inValid), .inReady(inReady),
    .statusN(statusN), .confDone(confDone), .bitActive(bitActive),
    .cmd(bitCmd), .cfgStartN(cfgStartN), .pciRstN(pciRstN),
    .busy(busy), .done(done), .err(err)
  );

  pser_cfg_dp #(.DIV_HALF(DIV_HALF)) i_dp (
    .clk(clk), .rstN(rstN), .cmd(bitCmd), .inData(inData),
    .cfgData(cfgData), .cfgClk(cfgClk), .bitActive(bitActive)
  );

endmodule

// File: rtl/pser_cfg_chk.sv
module pser_cfg_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic pciRstN,
  input logic cfgClk,
  input logic cfgData,
  input logic cfgStartN,
  input logic statusN,
  input logic inReady,
  input logic done
);
  // R2
  pci_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pciRstN == !busy);

  // R6
  data_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgClk) |-> $stable(cfgData));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgClk && $past(cfgClk)) |-> $stable(cfgData));

  // R6
  clk_when_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgClk |-> (cfgStartN && busy));

  // R3
  release_after_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cfgStartN) && busy) |-> $past(!statusN));

  // R7
  ready_clk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (!cfgClk && busy));

  // R10
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind pser_cfg_loader pser_cfg_chk i_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .pciRstN(pciRstN),
  .cfgClk(cfgClk), .cfgData(cfgData), .cfgStartN(cfgStartN),
  .statusN(statusN), .inReady(inReady), .done(done)
);

// File: tb/test_pser_cfg_loader.sv
module test_pser_cfg_loader;
  localparam int DIV_HALF = 2;
  localparam int LONG     = 400;
  localparam int SHORT    = 4;
  localparam int TRAIL    = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] byteCount = '0;
  logic [15:0] timeoutLimit = '0;
  logic [7:0]  inData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        stN = 1'b1;
  logic        cdone = 1'b0;
  logic        cfgStartN, cfgData, cfgClk, pciRstN, busy, done;
  logic [1:0]  err;

  int errs = 0;
  int checks = 0;

  // target and stream model state
  int nBytes, doneExtra, dLo, dHi, loCnt, hiCnt;
  bit allowLow, allowHigh, allowDone;
  int rises, trailCnt, onesAfter, preHi, lowLen, idx, accepted;
  bit prevClk, sawLow, pending, readySeen;
  logic [7:0] bytes [0:15];
  bit bits [0:255];

  always #4 clk = ~clk;

  pser_cfg_loader #(
    .DIV_HALF(DIV_HALF), .LONG_DLY(LONG), .SHORT_DLY(SHORT),
    .CNT_W(16), .TO_W(16), .TRAIL_CLKS(TRAIL)
  ) i_pser_cfg_loader (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount),
    .timeoutLimit(timeoutLimit), .inData(inData), .inValid(inValid),
    .inReady(inReady), .statusN(stN), .confDone(cdone),
    .cfgStartN(cfgStartN), .cfgData(cfgData), .cfgClk(cfgClk),
    .pciRstN(pciRstN), .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one model step, called at every falling edge of clk
  task automatic step();
    if (busy && cfgStartN && !sawLow) preHi++;
    if (busy && !cfgStartN) begin sawLow = 1; lowLen++; end
    if (!cfgStartN) begin
      hiCnt = 0;
      if (stN && allowLow) begin
        if (loCnt >= dLo) stN = 1'b0; else loCnt++;
      end
    end else begin
      loCnt = 0;
      if (!stN && allowHigh) begin
        if (hiCnt >= dHi) stN = 1'b1; else hiCnt++;
      end
    end
    if (cfgClk && !prevClk) begin
      if (cdone) trailCnt++;
      else begin
        if (rises < 8*nBytes) bits[rises] = cfgData;
        else if (cfgData) onesAfter++;
        rises++;
        if (allowDone && rises >= 8*nBytes + doneExtra) cdone = 1'b1;
      end
    end
    prevClk = cfgClk;
    if (pending) begin idx++; accepted++; end
    inValid = (idx < nBytes) && ($urandom % 4 != 0);
    inData  = bytes[(idx < 16) ? idx : 0];
    if (inReady) readySeen = 1;
    pending = inValid && inReady;
  endtask

  task automatic runJob(input int n, input int extra, input bit aL,
                        input bit aH, input bit aD, input int lim,
                        input bit midStart, input int expErr);
    bit midDone = 0;
    nBytes = n; doneExtra = extra; allowLow = aL; allowHigh = aH; allowDone = aD;
    dLo = $urandom_range(0, 5); dHi = $urandom_range(0, 5);
    for (int i = 0; i < 16; i++) bytes[i] = 8'($urandom);
    if (n >= 3) begin bytes[0] = 8'h01; bytes[1] = 8'h80; bytes[2] = 8'hA5; end
    stN = 1'b1; cdone = aD && (8*n + extra == 0);
    loCnt = 0; hiCnt = 0; rises = 0; trailCnt = 0; onesAfter = 0;
    preHi = 0; lowLen = 0; idx = 0; accepted = 0;
    prevClk = 0; sawLow = 0; pending = 0; readySeen = 0;
    byteCount = 16'(n); timeoutLimit = 16'(lim);
    @(negedge clk); start = 1'b1; step();
    @(negedge clk); start = 1'b0; step();
    // R10: previous job's status cleared by the new start
    chk(int'(err), 0, "R10 err cleared on start");
    chk(int'(done), 0, "R10 done cleared on start");
    chk(int'(pciRstN), 0, "R2 pci reset low while busy");
    while (busy) begin
      @(negedge clk);
      if (midStart && !midDone && rises == 12) begin start = 1'b1; midDone = 1; end
      else start = 1'b0;
      step();
    end
    start = 1'b0;
    chk(int'(err), expErr, "R4 R5 R8 R9 error code");
    chk(int'(done), 1, "R9 done after job");
    chk(int'(pciRstN), 1, "R2 pci reset released");
    chk(preHi, LONG, "R3 request high phase");
    if (expErr == 0) begin
      for (int b = 0; b < n; b++) begin
        logic [7:0] got;
        for (int k = 0; k < 8; k++) got[k] = bits[8*b + k];
        chk(int'(got), int'(bytes[b]), "R6 byte LSB first");
      end
      chk(accepted, n, "R7 bytes accepted");
      chk(rises, 8*n + extra, "R8 zero clocks until done");
      chk(onesAfter, 0, "R8 zero data after image");
      chk(trailCnt, TRAIL, "R9 trailing clocks");
      if (n == 0) chk(int'(readySeen), 0, "R11 no byte requested");
    end else if (expErr == 3) begin
      chk(rises, 8*n + lim, "R8 clocks before done timeout");
      chk(accepted, n, "R7 bytes accepted before timeout");
    end else begin
      chk(accepted, 0, "R5 no byte on status error");
      chk(rises, 0, "R5 no clock on status error");
      if (expErr == 1) chk(lowLen, SHORT + lim + 1, "R4 request low length");
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs + 1, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1
    chk(int'(cfgStartN), 1, "R1 reset cfgStartN");
    chk(int'(cfgClk), 0, "R1 reset cfgClk");
    chk(int'(pciRstN), 1, "R1 reset pciRstN");
    chk(int'(busy), 0, "R1 reset busy");
    chk(int'(done), 0, "R1 reset done");
    chk(int'(err), 0, "R1 reset err");
    chk(int'(inReady), 0, "R1 reset inReady");
    rstN = 1'b1;
    @(negedge clk);
    runJob(3, 0, 1, 1, 1, 50, 0, 0);
    for (int j = 0; j < 5; j++)
      runJob($urandom_range(1, 6), $urandom_range(0, 5), 1, 1, 1, 50, 0, 0);
    runJob(0, 2, 1, 1, 1, 50, 0, 0);      // R11
    runJob(4, 1, 1, 1, 1, 50, 1, 0);      // R10 start while busy
    runJob(2, 0, 0, 1, 1, 20, 0, 1);      // R4
    runJob(2, 0, 1, 0, 1, 20, 0, 2);      // R5
    runJob(3, 0, 1, 1, 1, 40, 0, 0);      // R10 clear after error
    runJob(2, 0, 1, 1, 0, 7, 0, 3);       // R8 done timeout
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule